// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Controller

This block keeps a local copy of the serial configuration chain of a phase-locked loop. It lets a host read or change one counter parameter at a time in that copy. A counter is chosen by a 4-bit code and a parameter by a 3-bit code. Parameters are 9, 4 or 1 bits wide and all share one 9-bit data path. Only the local copy changes during a read or a write; the PLL itself is not touched.

On a reconfigure request the controller first pulses a scan clear. It then shifts the whole copy into the PLL, one bit per scan-clock period, with the scan clock at half the system clock. The host sees a single busy flag. While that flag is high, every new request is dropped. The PLL's own scan output comes back as an input; the controller carries it but does not act on it.

Top module: `pll_scan_ctrl`

## Requirements
- R1: Asynchronous reset (`rst` high) clears the cache to all zeros and drives `busy`, `dataOut`, `scanClk` and `scanClr` low.
- R2: Counter codes map to 24-bit slots in the chain. Slot index is 0 for code 0 (N) and 1 for code 1 (M); 2..5 for codes 4..7; 6..7 for codes 8..9; and 8..11 for codes 12..15. Codes 2, 3, 10 and 11 are invalid, and so are codes 12..15 when `LONG_CHAIN` is 0 (192-bit chain). A write to an invalid code changes nothing, and a read of one returns zero.
- R3: Within a slot starting at bit 24*slot, the fields sit at these offsets: a 9-bit count at offset 0, a 9-bit count at offset 9, a 4-bit delay at offset 18, the bypass bit at 22 and the odd-division bit at 23. Data is right-aligned on `dataIn` and `dataOut`. A write stores only the field's width, and a read returns zero in the unused upper bits.
- R4: Parameter codes 0 and 1 (nominal and spread count, offsets 0 and 9) are valid only for N and M. Codes 2 and 3 (high and low count, offsets 0 and 9) are valid only for the other counters. Code 4 is the delay, 6 the bypass bit and 7 the odd-division bit; code 7 is invalid for N and M, so their odd bit stays 0. Code 5 is invalid. Invalid accesses behave as in R2.
- R5: An accepted read or write raises `busy` for exactly one cycle, starting the cycle after the request. A read's result is on `dataOut` in that same cycle and is held until the next accepted read.
- R6: A request that arrives while `busy` is high is ignored: neither the cache nor `dataOut` changes.
- R7: When several requests arrive together while idle, reconfigure wins over write, and write wins over read. The losing requests are dropped.
- R8: An accepted reconfigure holds `scanClr` high for the two cycles after the request, with `scanClk` low throughout.
- R9: After the clear, the chain is shifted out most significant bit first. `scanClk` is low for one cycle and then high for one cycle for each bit. `scanData` changes only while `scanClk` is low, and after the shift the PLL holds an exact copy of the cache.
- R10: `busy` falls one cycle after the high phase of the last bit, after exactly 288 (or 192) scan-clock rising edges. The cache is unchanged by the reconfigure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| dataIn | input | 9 | Write data, right-aligned |
| counterSel | input | 4 | Counter code |
| paramSel | input | 3 | Parameter code |
| readReq | input | 1 | One-cycle read request |
| writeReq | input | 1 | One-cycle write request |
| reconfigReq | input | 1 | One-cycle reconfigure request |
| scanRet | input | 1 | Scan data returned by the PLL |
| dataOut | output | 9 | Read data, right-aligned |
| busy | output | 1 | Operation in progress |
| scanClk | output | 1 | Scan clock to the PLL |
| scanClr | output | 1 | Scan clear to the PLL |
| scanData | output | 1 | Serial data to the PLL |

## Verification
The assertions assume that requests are synchronous to `clk` and held for a single cycle. They also assume the host keeps `counterSel`, `paramSel` and `dataIn` steady on the cycle a request is sampled. The stimulus changes every input at the falling clock edge and drops each request one cycle after raising it. Requests made while busy, or several at once, are issued on purpose to cover R6 and R7, so the properties about one-cycle busy only fire for a lone read or write accepted while idle.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;
  localparam int SLOT_W    = 24;
  localparam int DATA_W    = 9;
  localparam int LONG_CNT  = 12;
  localparam int SHORT_CNT = 8;

  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic doRotate;
  } ctrlStrobe_t;

  typedef struct packed {
    logic       ok;
    logic [8:0] base;
    logic [3:0] width;
  } fieldLoc_t;

  function automatic fieldLoc_t locateField(input logic [3:0] code,
                                            input logic [2:0] par,
                                            input logic longChain);
    fieldLoc_t loc;
    logic [3:0] slot;
    logic       isMN;
    logic [4:0] off;
    loc   = '0;
    slot  = '0;
    off   = '0;
    isMN  = (code < 4'd2);
    loc.ok = 1'b1;
    if (code < 4'd2)       slot = code;
    else if (code < 4'd4)  loc.ok = 1'b0;
    else if (code < 4'd10) slot = code - 4'd2;
    else if (code < 4'd12) loc.ok = 1'b0;
    else begin
      slot = code - 4'd4;
      if (!longChain) loc.ok = 1'b0;
    end
    case (par)
      3'd0: begin off = 5'd0;  loc.width = 4'd9; if (!isMN) loc.ok = 1'b0; end
      3'd1: begin off = 5'd9;  loc.width = 4'd9; if (!isMN) loc.ok = 1'b0; end
      3'd2: begin off = 5'd0;  loc.width = 4'd9; if (isMN)  loc.ok = 1'b0; end
      3'd3: begin off = 5'd9;  loc.width = 4'd9; if (isMN)  loc.ok = 1'b0; end
      3'd4: begin off = 5'd18; loc.width = 4'd4; end
      3'd6: begin off = 5'd22; loc.width = 4'd1; end
      3'd7: begin off = 5'd23; loc.width = 4'd1; if (isMN) loc.ok = 1'b0; end
      default: loc.ok = 1'b0;
    endcase
    loc.base = 9'(slot) * 9'(SLOT_W) + 9'(off);
    return loc;
  endfunction
endpackage

// File: rtl/pll_scan_datapath.sv
module pll_scan_datapath
  import pll_scan_pkg::*;
#(
  parameter bit LONG_CHAIN = 1'b1,
  parameter int CHAIN_LEN  = 288
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       stb,
  input  logic [3:0]        counterSel,
  input  logic [2:0]        paramSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              scanData
);
  localparam int IDX_W = $clog2(CHAIN_LEN);

  logic [CHAIN_LEN-1:0] cache;
  logic [CHAIN_LEN-1:0] cacheWr;
  logic [DATA_W-1:0]    rdVal;
  logic [IDX_W-1:0]     baseIdx;
  fieldLoc_t            loc;

  always_comb begin
    loc     = locateField(counterSel, paramSel, LONG_CHAIN);
    baseIdx = IDX_W'(loc.base);
    cacheWr = cache;
    rdVal   = '0;
    if (loc.ok) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (b < int'(loc.width)) begin
          cacheWr[baseIdx + IDX_W'(b)] = dataIn[b];
          rdVal[b] = cache[baseIdx + IDX_W'(b)];
        end
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cache   <= '0;
      dataOut <= '0;
    end else begin
      if (stb.doRotate)
        cache <= {cache[CHAIN_LEN-2:0], cache[CHAIN_LEN-1]};
      else if (stb.doWrite)
        cache <= cacheWr;
      if (stb.doRead)
        dataOut <= rdVal;
    end
  end

  assign scanData = cache[CHAIN_LEN-1];
endmodule

// File: rtl/pll_scan_control.sv
module pll_scan_control
  import pll_scan_pkg::*;
#(
  parameter int CHAIN_LEN = 288
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        readReq,
  input  logic        writeReq,
  input  logic        reconfigReq,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        scanClk,
  output logic        scanClr
);
  localparam int CNT_W = $clog2(CHAIN_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAIN_LEN - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ACC, ST_CLR, ST_SHIFT, ST_TAIL} state_t;

  state_t           state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             phase;

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_IDLE: begin
        if (reconfigReq) nxt = ST_CLR;
        else if (writeReq) begin stb.doWrite = 1'b1; nxt = ST_ACC; end
        else if (readReq)  begin stb.doRead  = 1'b1; nxt = ST_ACC; end
      end
      ST_ACC: nxt = ST_IDLE;
      ST_CLR: if (cnt == CNT_W'(1)) nxt = ST_SHIFT;
      ST_SHIFT: begin
        if (phase) begin
          stb.doRotate = 1'b1;
          if (cnt == LAST_BIT) nxt = ST_TAIL;
        end
      end
      ST_TAIL: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      state <= nxt;
      phase <= (state == ST_SHIFT) ? ~phase : 1'b0;
      if (nxt != state)
        cnt <= '0;
      else if (state == ST_CLR || (state == ST_SHIFT && phase))
        cnt <= cnt + CNT_W'(1);
    end
  end

  assign busy    = (state != ST_IDLE);
  assign scanClk = phase;
  assign scanClr = (state == ST_CLR);
endmodule

// File: rtl/pll_scan_ctrl.sv
module pll_scan_ctrl
  import pll_scan_pkg::*;
#(
  parameter bit LONG_CHAIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [8:0] dataIn,
  input  logic [3:0] counterSel,
  input  logic [2:0] paramSel,
  input  logic       readReq,
  input  logic       writeReq,
  input  logic       reconfigReq,
  input  logic       scanRet,
  output logic [8:0] dataOut,
  output logic       busy,
  output logic       scanClk,
  output logic       scanClr,
  output logic       scanData
);
  localparam int CHAIN_LEN = (LONG_CHAIN ? LONG_CNT : SHORT_CNT) * SLOT_W;

  ctrlStrobe_t stb;
  logic        unusedScanRet;

  assign unusedScanRet = scanRet;

  pll_scan_control #(.CHAIN_LEN(CHAIN_LEN)) u_control (
    .clk(clk), .rst(rst), .readReq(readReq), .writeReq(writeReq),
    .reconfigReq(reconfigReq), .stb(stb), .busy(busy),
    .scanClk(scanClk), .scanClr(scanClr)
  );

  pll_scan_datapath #(.LONG_CHAIN(LONG_CHAIN), .CHAIN_LEN(CHAIN_LEN)) u_datapath (
    .clk(clk), .rst(rst), .stb(stb), .counterSel(counterSel),
    .paramSel(paramSel), .dataIn(dataIn), .dataOut(dataOut),
    .scanData(scanData)
  );
endmodule

// File: rtl/pll_scan_ctrl_chk.sv
module pll_scan_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       readReq,
  input logic       writeReq,
  input logic       reconfigReq,
  input logic [8:0] dataOut,
  input logic       busy,
  input logic       scanClk,
  input logic       scanClr,
  input logic       scanData
);
  AST_CLR_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    scanClr |-> !scanClk); // R8
  AST_CLR_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && reconfigReq) |=> scanClr); // R7
  AST_CLR_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $rose(scanClr) |=> scanClr ##1 !scanClr); // R8
  AST_SCK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    scanClk |-> busy); // R9
  AST_SCK_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    scanClk |=> !scanClk); // R9
  AST_SDATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(scanClk) |-> $stable(scanData)); // R9
  AST_RW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !reconfigReq && (readReq || writeReq)) |=> busy ##1 !busy); // R5
  AST_DOUT_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dataOut)); // R6
  AST_BUSY_END_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!scanClk && !scanClr)); // R10
endmodule

bind pll_scan_ctrl pll_scan_ctrl_chk u_chk (.*);

// File: tb/pll_scan_ctrl_bench.sv
module pll_scan_ctrl_bench;
  localparam int L = 288;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] dataIn = '0;
  logic [3:0] counterSel = '0;
  logic [2:0] paramSel = '0;
  logic       readReq = 1'b0, writeReq = 1'b0, reconfigReq = 1'b0;
  logic       scanRet;
  logic [8:0] dataOut;
  logic       busy, scanClk, scanClr, scanData;

  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  pll_scan_ctrl u_pll_scan_ctrl (.*);

  // PLL stand-in: plain shift register
  logic [L-1:0] pllReg = '0;
  int riseCnt = 0;
  always @(posedge scanClk or posedge scanClr)
    if (scanClr) pllReg <= '0;
    else begin
      pllReg  <= {pllReg[L-2:0], scanData};
      riseCnt <= riseCnt + 1;
    end
  assign scanRet = pllReg[L-1];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference model
  logic [L-1:0] mCache = '0;
  int mOut = 0;
  bit eBusy = 0, eClk = 0, eClr = 0;
  int eData = -1;
  int qClk[$], qClr[$], qData[$];

  function automatic bit mLoc(input int code, input int par, output int base, output int w);
    int slot; int off; bit mn;
    base = 0; w = 0;
    case (code)
      0, 1:            slot = code;
      4, 5, 6, 7, 8, 9: slot = code - 2;
      12, 13, 14, 15:  slot = code - 4;
      default: return 0;
    endcase
    mn = (code <= 1);
    case (par)
      0: begin if (!mn) return 0; off = 0;  w = 9; end
      1: begin if (!mn) return 0; off = 9;  w = 9; end
      2: begin if (mn) return 0;  off = 0;  w = 9; end
      3: begin if (mn) return 0;  off = 9;  w = 9; end
      4: begin off = 18; w = 4; end
      6: begin off = 22; w = 1; end
      7: begin if (mn) return 0;  off = 23; w = 1; end
      default: return 0;
    endcase
    base = slot * 24 + off;
    return 1;
  endfunction

  task automatic push(input int c, input int r, input int d);
    qClk.push_back(c); qClr.push_back(r); qData.push_back(d);
  endtask

  always @(posedge clk or posedge rst) begin
    int base, w;
    if (rst) begin
      mCache = '0; mOut = 0; eBusy = 0; eClk = 0; eClr = 0; eData = -1;
      qClk.delete(); qClr.delete(); qData.delete();
    end else begin
      if (!eBusy) begin
        if (reconfigReq) begin
          push(0, 1, -1); push(0, 1, -1);
          for (int i = L - 1; i >= 0; i--) begin
            push(0, 0, int'(mCache[i])); push(1, 0, int'(mCache[i]));
          end
          push(0, 0, -1);
        end else if (writeReq) begin
          if (mLoc(counterSel, paramSel, base, w))
            for (int b = 0; b < w; b++) mCache[base + b] = dataIn[b];
          push(0, 0, -1);
        end else if (readReq) begin
          mOut = 0;
          if (mLoc(counterSel, paramSel, base, w))
            for (int b = 0; b < w; b++) mOut[b] = mCache[base + b];
          push(0, 0, -1);
        end
      end
      if (qClk.size() > 0) begin
        eBusy = 1; eClk = qClk.pop_front(); eClr = qClr.pop_front(); eData = qData.pop_front();
      end else begin
        eBusy = 0; eClk = 0; eClr = 0; eData = -1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) if (!rst) begin
    chk(busy == eBusy, "R5 busy", busy, eBusy);
    chk(int'(dataOut) == mOut, "R3 dataOut", dataOut, mOut);
    chk(scanClr == eClr, "R8 scanClr", scanClr, eClr);
    chk(scanClk == eClk, "R9 scanClk", scanClk, eClk);
    if (eData >= 0) chk(int'(scanData) == eData, "R9 scanData", scanData, eData);
  end

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic wr(input int code, input int par, input int val);
    @(negedge clk);
    counterSel = 4'(code); paramSel = 3'(par); dataIn = 9'(val); writeReq = 1'b1;
    @(negedge clk);
    writeReq = 1'b0;
    waitIdle();
  endtask

  task automatic rd(input int code, input int par, input int exp, input string tag);
    @(negedge clk);
    counterSel = 4'(code); paramSel = 3'(par); readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    chk(busy == 1'b1, {tag, " busy during read"}, busy, 1);
    chk(int'(dataOut) == exp, tag, dataOut, exp);
    waitIdle();
  endtask

  task automatic reconfigure();
    @(negedge clk);
    riseCnt = 0;
    reconfigReq = 1'b1;
    @(negedge clk);
    reconfigReq = 1'b0;
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && dataOut == 0 && scanClk == 0 && scanClr == 0, "R1 reset outputs",
        {busy, dataOut, scanClk, scanClr}, 0);
    rst = 1'b0;
    rd(0, 0, 0, "R1 cache zero after reset");

    wr(0, 0, 9'h1A5);  rd(0, 0, 9'h1A5, "R2 N nominal");
    wr(15, 3, 9'h0F3); rd(15, 3, 9'h0F3, "R2 e3 low count");
    wr(1, 1, 9'h066);  rd(1, 1, 9'h066, "R2 M spread");
    wr(6, 4, 9'h1FE);  rd(6, 4, 9'h00E, "R3 delay 4 bits");
    wr(9, 6, 9'h1FF);  rd(9, 6, 9'h001, "R3 bypass 1 bit");
    wr(5, 7, 9'h001);  rd(5, 7, 9'h001, "R4 a1 odd bit");
    wr(2, 2, 9'h1FF);  rd(2, 2, 0, "R2 unused code 2");
    rd(10, 0, 0, "R2 unused code 10");
    wr(4, 5, 9'h1FF);  rd(4, 5, 0, "R4 unused param 5");
    wr(1, 2, 9'h0AB);  rd(1, 2, 0, "R4 high count on M");
    rd(1, 0, 0, "R4 M nominal untouched");
    wr(0, 7, 9'h001);  rd(0, 7, 0, "R4 odd bit of N");
    rd(0, 4, 0, "R4 N slot untouched by odd write");
    wr(4, 0, 9'h001);  rd(4, 2, 0, "R4 nominal on a0");

    // R6: second write while busy is dropped
    @(negedge clk);
    counterSel = 4'd8; paramSel = 3'd2; dataIn = 9'h111; writeReq = 1'b1;
    @(negedge clk);
    paramSel = 3'd3; dataIn = 9'h123;
    @(negedge clk);
    writeReq = 1'b0;
    waitIdle();
    rd(8, 3, 0, "R6 write during busy ignored");
    rd(8, 2, 9'h111, "R6 first write kept");

    // R7: reconfigure beats write in the same cycle
    @(negedge clk);
    riseCnt = 0;
    counterSel = 4'd12; paramSel = 3'd2; dataIn = 9'h055;
    reconfigReq = 1'b1; writeReq = 1'b1; readReq = 1'b1;
    @(negedge clk);
    reconfigReq = 1'b0; writeReq = 1'b0; readReq = 1'b0;
    waitIdle();
    rd(12, 2, 0, "R7 write lost to reconfigure");
    chk(pllReg == mCache, "R9 PLL copy after first reconfigure", int'(pllReg[31:0]), int'(mCache[31:0]));
    chk(riseCnt == L, "R10 rising edge count", riseCnt, L);

    // R7: write beats read
    @(negedge clk);
    counterSel = 4'd13; paramSel = 3'd3; dataIn = 9'h0C3; writeReq = 1'b1; readReq = 1'b1;
    @(negedge clk);
    writeReq = 1'b0; readReq = 1'b0;
    chk(int'(dataOut) == mOut, "R7 dataOut not reloaded by losing read", dataOut, mOut);
    waitIdle();
    rd(13, 3, 9'h0C3, "R7 write won over read");

    wr(7, 2, 9'h15A); wr(14, 4, 9'h009);
    reconfigure();
    chk(pllReg == mCache, "R9 PLL copy matches cache", int'(pllReg[31:0]), int'(mCache[31:0]));
    chk(riseCnt == L, "R10 rising edge count", riseCnt, L);
    rd(0, 0, 9'h1A5, "R10 cache kept after reconfigure");
    rd(7, 2, 9'h15A, "R10 a3 kept after reconfigure");
    rd(15, 3, 9'h0F3, "R10 e3 kept after reconfigure");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nRun++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule